// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is a purely combinational arithmetic-logic unit that works on either 8-bit or 16-bit operands, chosen by a single width bit. It covers ten operations: add, subtract, compare, increment, decrement, negate, and the bitwise operations AND, OR, XOR and NOT. From the operands, the opcode, the width bit and the current 16-bit flag word it produces three outputs: the result, the next flag word, and a write-enable that says whether the result should be stored.

Each operation updates the flag word by its own rules. The surrounding datapath feeds the returned flag word back in as the current flags on the next operation. It writes the result to its destination only when the write-enable is high. Compare therefore changes only the flags. All control bits and every unassigned bit of the flag word pass through unchanged.

Top module: `alu_bw`

## Requirements
- R1: The status flags sit at fixed bit positions of the flag word: carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. All other bits are copied from the input flag word to the output unchanged, for every opcode. This includes the control bits 8, 9 and 10.
- R2: Opcode encoding is ADD=0, SUB=1, CMP=2, INC=3, DEC=4, NEG=5, AND=6, OR=7, XOR=8, NOT=9. Write-enable is 1 for every defined opcode except CMP. Opcodes 10 to 15 give a result of 0, write-enable 0 and an unchanged flag word.
- R3: With the width bit at 1, the unit works on all 16 bits. With it at 0, only the low 8 bits of each operand are used, bits 15:8 of the result are 0, and the carry, sign and overflow flags are taken at bit 7.
- R4: ADD gives a+b and SUB gives a-b, both modulo the width. Carry is set when a carry (ADD) or a borrow (SUB) leaves the top bit of the selected width.
- R5: For ADD and INC, overflow is set when both inputs have the same sign and the result's sign differs from it. For SUB, CMP, DEC and NEG, overflow is set when the inputs' signs differ and the result's sign differs from the minuend's.
- R6: For the arithmetic opcodes, half-carry is the carry (for addition) or borrow (for subtraction) between bit 3 and bit 4. The logical opcodes AND, OR and XOR clear it.
- R7: Except for NOT, every defined opcode sets zero when the result is 0 and copies the result's top bit into sign. Parity is set when the low 8 bits of the result hold an even number of ones, also in word mode.
- R8: CMP updates the flags exactly as SUB with the same operands would, and holds write-enable at 0.
- R9: INC gives a+1 and DEC gives a-1. Both update overflow, half-carry, zero, sign and parity and keep carry at its input value.
- R10: NEG gives 0-a. Carry is 1 for a nonzero operand and 0 for a zero one. For example, 15h gives EBh with carry set.
- R11: AND, OR and XOR clear carry and overflow. For example, 61h AND CFh gives 41h.
- R12: NOT gives the bitwise complement of a within the selected width and changes no flag. For example, 39h gives C6h in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (encoding in R2) |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opd_a | input | 16 | Destination / first operand |
| opd_b | input | 16 | Source / second operand |
| flags_in | input | 16 | Current flag word |
| result | output | 16 | Operation result |
| result_we | output | 1 | Result write-enable, low for CMP and undefined opcodes |
| flags_out | output | 16 | Next flag word |

## Verification
Two updates often land on the same operation. A carry or borrow out of the top bit is judged together with the signed overflow. Several flag rules meet at once at the width boundary: at 7Fh+1 or 80h-1, INC and DEC change overflow, half-carry, sign and zero in the same operation that must leave carry alone. These cases come up in the full byte-mode sweep of every operand pair for ADD and SUB, and in word-mode runs over sign-edge values. Each operation is run twice, with the carry-in cleared and with it set, so that a lost or wrongly altered carry shows up in the flag word. Every output is compared against an integer model that recomputes the signed range and the nibble carry independently.

// File: rtl/alu_bw_pkg.sv
package alu_bw_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_INC = 4'd3,
    OP_DEC = 4'd4,
    OP_NEG = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_NOT = 4'd9
  } alu_op_e;

  localparam int FB_CARRY = 0;
  localparam int FB_PAR   = 2;
  localparam int FB_HALF  = 4;
  localparam int FB_ZERO  = 6;
  localparam int FB_SIGN  = 7;
  localparam int FB_OVF   = 11;

  localparam logic [15:0] STATUS_MASK = 16'h08D5;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;

endpackage

// File: rtl/alu_bw_addsub.sv
module alu_bw_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          sub,
  input  logic          wide,
  output logic [DW-1:0] r,
  output logic          cf,
  output logic          af,
  output logic          of
);
  localparam int HW = DW / 2;

  logic [DW-1:0] mask;
  logic [DW-1:0] xm;
  logic [DW-1:0] ym;
  logic [DW-1:0] yop;
  logic [DW:0]   sum;
  logic          cout;
  logic          xs, ys, rs;

  always_comb begin
    mask = wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    xm   = x & mask;
    ym   = y & mask;
    yop  = (sub ? ~y : y) & mask;
    sum  = {1'b0, xm} + {1'b0, yop} + {{DW{1'b0}}, sub};
    r    = sum[DW-1:0] & mask;
    cout = wide ? sum[DW] : sum[HW];
    cf   = cout ^ sub;
    af   = xm[4] ^ ym[4] ^ r[4];
    xs   = wide ? xm[DW-1] : xm[HW-1];
    ys   = wide ? ym[DW-1] : ym[HW-1];
    rs   = wide ? r[DW-1]  : r[HW-1];
    of   = sub ? ((xs != ys) && (rs != xs)) : ((xs == ys) && (rs != xs));
  end
endmodule

// File: rtl/alu_bw_logic.sv
module alu_bw_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  input  alu_bw_pkg::logic_sel_e sel,
  input  logic                   wide,
  output logic [DW-1:0]          r
);
  import alu_bw_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] raw;
  logic [DW-1:0] mask;

  always_comb begin
    mask = wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    unique case (sel)
      LG_AND:  raw = a & b;
      LG_OR:   raw = a | b;
      LG_XOR:  raw = a ^ b;
      default: raw = ~a;
    endcase
    r = raw & mask;
  end
endmodule

// File: rtl/alu_bw_status.sv
module alu_bw_status #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] r,
  input  logic          wide,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  localparam int HW = DW / 2;

  always_comb begin
    zf = (r == '0);
    sf = wide ? r[DW-1] : r[HW-1];
    pf = ~(^r[7:0]);
  end
endmodule

// File: rtl/alu_bw.sv
module alu_bw #(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] opd_a,
  input  logic [DW-1:0] opd_b,
  input  logic [15:0]   flags_in,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [15:0]   flags_out
);
  import alu_bw_pkg::*;

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e       opc;
  logic [DW-1:0] ax, ay;
  logic          asub;
  logic [DW-1:0] ar;
  logic          acf, aaf, aof;
  logic_sel_e    lsel;
  logic [DW-1:0] lr;
  logic          zf, sf, pf;
  logic [DW-1:0] rsel;
  logic          is_arith, is_logic;

  assign opc = alu_op_e'(op);

  // operand routing for the shared adder
  always_comb begin
    ax   = opd_a;
    ay   = opd_b;
    asub = 1'b0;
    unique case (opc)
      OP_SUB, OP_CMP: asub = 1'b1;
      OP_INC: ay = ONE;
      OP_DEC: begin ay = ONE; asub = 1'b1; end
      OP_NEG: begin ax = '0; ay = opd_a; asub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (opc)
      OP_AND:  lsel = LG_AND;
      OP_OR:   lsel = LG_OR;
      OP_XOR:  lsel = LG_XOR;
      default: lsel = LG_NOT;
    endcase
  end

  alu_bw_addsub #(.DW(DW)) u_addsub (
    .x(ax), .y(ay), .sub(asub), .wide(wide),
    .r(ar), .cf(acf), .af(aaf), .of(aof)
  );

  alu_bw_logic #(.DW(DW)) u_logic (
    .a(opd_a), .b(opd_b), .sel(lsel), .wide(wide), .r(lr)
  );

  always_comb begin
    is_arith = (op <= 4'd5);
    is_logic = (op >= 4'd6) && (op <= 4'd9);
    if (is_arith)      rsel = ar;
    else if (is_logic) rsel = lr;
    else               rsel = '0;
  end

  alu_bw_status #(.DW(DW)) u_status (
    .r(rsel), .wide(wide), .zf(zf), .sf(sf), .pf(pf)
  );

  always_comb begin
    result    = rsel;
    result_we = (is_arith || is_logic) && (opc != OP_CMP);
    flags_out = flags_in;
    if (is_arith) begin
      if (opc != OP_INC && opc != OP_DEC) flags_out[FB_CARRY] = acf;
      flags_out[FB_HALF] = aaf;
      flags_out[FB_OVF]  = aof;
      flags_out[FB_ZERO] = zf;
      flags_out[FB_SIGN] = sf;
      flags_out[FB_PAR]  = pf;
    end else if (is_logic && opc != OP_NOT) begin
      flags_out[FB_CARRY] = 1'b0;
      flags_out[FB_HALF]  = 1'b0;
      flags_out[FB_OVF]   = 1'b0;
      flags_out[FB_ZERO]  = zf;
      flags_out[FB_SIGN]  = sf;
      flags_out[FB_PAR]   = pf;
    end
  end
endmodule

// File: rtl/alu_bw_chk.sv
module alu_bw_chk #(
  parameter int DW = 16
) (
  input logic [3:0]    op,
  input logic          wide,
  input logic [DW-1:0] opd_a,
  input logic [DW-1:0] opd_b,
  input logic [15:0]   flags_in,
  input logic [DW-1:0] result,
  input logic          result_we,
  input logic [15:0]   flags_out
);
  import alu_bw_pkg::*;
  localparam int HW = DW / 2;

  always_comb begin
    AST_PASS_BITS: assert ((flags_out & ~STATUS_MASK) == (flags_in & ~STATUS_MASK)); // R1
    if (op == 4'd2) begin
      AST_CMP_NO_WRITE: assert (!result_we); // R8
    end
    if (op >= 4'd10) begin
      AST_UNDEF_QUIET: assert (!result_we && result == '0 && flags_out == flags_in); // R2
    end
    if (!wide) begin
      AST_BYTE_HIGH_ZERO: assert (result[DW-1:HW] == '0); // R3
    end
    if (op == 4'd3 || op == 4'd4) begin
      AST_INCDEC_CARRY: assert (flags_out[FB_CARRY] == flags_in[FB_CARRY]); // R9
    end
    if (op == 4'd5 && wide) begin
      AST_NEG_CARRY: assert (flags_out[FB_CARRY] == (opd_a != '0)); // R10
    end
    if (op >= 4'd6 && op <= 4'd8) begin
      AST_LOGIC_CLEAR: assert (!flags_out[FB_CARRY] && !flags_out[FB_OVF]); // R11
    end
    if (op == 4'd9) begin
      AST_NOT_FLAGS: assert (flags_out == flags_in); // R12
    end
    if (op <= 4'd8) begin
      AST_ZERO_FLAG: assert (flags_out[FB_ZERO] == (result == '0)); // R7
    end
    if (op == 4'd0 && wide) begin
      AST_ADD_SUM: assert (result == opd_a + opd_b); // R4
    end
    if (op == 4'd7) begin
      AST_OR_NO_ONES_LOST: assert (((opd_b | opd_a) & ~result & (wide ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}})) == '0); // R11
    end
  end
endmodule

bind alu_bw alu_bw_chk #(.DW(DW)) u_chk (
  .op(op), .wide(wide), .opd_a(opd_a), .opd_b(opd_b), .flags_in(flags_in),
  .result(result), .result_we(result_we), .flags_out(flags_out)
);

// File: tb/alu_bw_tb.sv
module alu_bw_tb;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic        wide;
  logic [15:0] opd_a, opd_b, flags_in;
  logic [15:0] result;
  logic        result_we;
  logic [15:0] flags_out;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_bw u_dut (
    .op(op), .wide(wide), .opd_a(opd_a), .opd_b(opd_b), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_out(flags_out)
  );

  function automatic int sgn(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic void model(input int o, input int a, input int b, input bit wd,
                                input int fin, output int res, output bit we, output int fo);
    int w, mx, x, y, r, s, c, af, ov, lo, hi;
    bit arith, keepc, logic_op, sub;
    w = wd ? 16 : 8;
    mx = (1 << w) - 1;
    lo = -(1 << (w - 1));
    hi = (1 << (w - 1)) - 1;
    x = a & mx; y = b & mx;
    arith = 0; keepc = 0; logic_op = 0; sub = 0;
    res = 0; we = 1; fo = fin; r = 0; c = 0; af = 0; ov = 0;
    case (o)
      0: begin arith = 1; end
      1, 2: begin arith = 1; sub = 1; if (o == 2) we = 0; end
      3: begin arith = 1; keepc = 1; y = 1; end
      4: begin arith = 1; keepc = 1; sub = 1; y = 1; end
      5: begin arith = 1; sub = 1; y = x; x = 0; end
      6: begin logic_op = 1; r = x & y; end
      7: begin logic_op = 1; r = x | y; end
      8: begin logic_op = 1; r = x ^ y; end
      9: begin res = (~x) & mx; return; end
      default: begin we = 0; return; end
    endcase
    if (arith) begin
      if (sub) begin
        r = (x - y) & mx; c = (x < y); af = ((x & 15) < (y & 15));
        s = sgn(x, w) - sgn(y, w);
      end else begin
        r = (x + y) & mx; c = ((x + y) > mx); af = (((x & 15) + (y & 15)) > 15);
        s = sgn(x, w) + sgn(y, w);
      end
      ov = (s < lo || s > hi);
      if (!keepc) fo = (fo & ~1) | c;
      fo = (fo & ~32'h10) | (af << 4);
      fo = (fo & ~32'h800) | (ov << 11);
    end else if (logic_op) begin
      fo = fo & ~32'h811;
    end
    res = r;
    fo = (fo & ~32'hC4) | ((r == 0) << 6) | (((r >> (w - 1)) & 1) << 7)
         | (((($countones(r & 255) % 2) == 0) ? 1 : 0) << 2);
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R4";
      2: return "R8";
      3, 4: return "R9";
      5: return "R10";
      6, 7, 8: return "R11";
      9: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input int o, input int a, input int b, input bit wd, input int fin);
    int er, ef;
    bit ew;
    op = o[3:0]; opd_a = a[15:0]; opd_b = b[15:0]; wide = wd; flags_in = fin[15:0];
    #1;
    model(o, a & 16'hFFFF, b & 16'hFFFF, wd, fin & 16'hFFFF, er, ew, ef);
    n_vec++;
    if (result !== er[15:0] || result_we !== ew || flags_out !== ef[15:0]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h w=%0b fin=%h: got res=%h we=%0b fl=%h expected res=%h we=%0b fl=%h",
               tag_of(o), o, a, b, wd, fin, result, result_we, flags_out, er[15:0], ew, ef[15:0]);
    end
    #1;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  localparam int NW = 12;
  int wv [NW] = '{0, 1, 2, 16'h000F, 16'h0010, 16'h007F, 16'h0080, 16'h00FF,
                  16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    op = 0; wide = 0; opd_a = 0; opd_b = 0; flags_in = 0;
    #2;
    // all-zero input state: ADD 0+0 -> zero and parity set
    apply(0, 0, 0, 0, 0);
    // R1: pass-through bits with all flags set in
    apply(0, 16'h0001, 16'h0001, 1, 16'hFFFF);
    check("R1", flags_out & 16'hF72A, 16'hF72A);
    apply(7, 16'h0100, 0, 1, 16'h0700);
    check("R1", flags_out[10:8], 3'b111);
    // R10 / R11 / R12 worked examples
    apply(5, 16'h15, 0, 0, 0);
    check("R10", result, 16'h00EB); check("R10", flags_out[0], 1);
    apply(5, 0, 0, 0, 1);
    check("R10", flags_out[0], 0);
    apply(6, 16'h61, 16'hCF, 0, 16'hFFFF);
    check("R11", result, 16'h0041);
    apply(9, 16'h39, 0, 0, 16'h0ABC);
    check("R12", result, 16'h00C6); check("R12", flags_out, 16'h0ABC);
    // R3: byte mode ignores high bytes
    apply(0, 16'hAB80, 16'hCD80, 0, 0);
    check("R3", result, 16'h0000); check("R3", flags_out[0], 1); check("R5", flags_out[11], 1);
    // R6: nibble carry
    apply(0, 16'h0F, 16'h01, 0, 0);
    check("R6", flags_out[4], 1);
    // R7: parity from low byte only in word mode
    apply(0, 16'h0100, 16'h0200, 1, 0);
    check("R7", flags_out[2], 1);
    // R9: INC at 7Fh keeps carry, sets overflow
    apply(3, 16'h7F, 0, 0, 1);
    check("R9", flags_out[0], 1); check("R5", flags_out[11], 1);
    // R8: compare leaves no write
    apply(2, 5, 5, 1, 0);
    check("R8", result_we, 0); check("R8", flags_out[6], 1);
    // R2: undefined opcodes
    for (int o = 10; o < 16; o++) apply(o, 16'h1234, 16'h4321, 1, 16'h5A5A);

    // full byte sweep for ADD and SUB
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        apply(0, a, b, 0, (a & 1) ? 16'h0001 : 16'h0000);
        apply(1, a, b, 0, (b & 1) ? 16'h0F00 : 16'h0000);
      end
    // byte sweep for the rest with a stepped second operand
    for (int o = 2; o < 10; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 37) begin
          apply(o, a, b, 0, 0);
          apply(o, a, b, 0, 16'hFFFF);
        end
    // word-mode corner grid
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < NW; i++)
        for (int j = 0; j < NW; j++) begin
          apply(o, wv[i], wv[j], 1, 0);
          apply(o, wv[i], wv[j], 1, 16'hFFFF);
        end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule